// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block sits between a serial character receiver and whatever reads the received bytes. It holds up to 64 received bytes, each stored next to the parity-error flag the receiver produced for it, and hands them out in arrival order through a simple read strobe. Four sticky status bits report that data is waiting, that the fill level has passed a programmable threshold, that a byte was lost because the queue was full, and that the line has gone quiet for a programmed interval while data is still waiting.

The quiet interval is measured with two cascaded dividers and a tick counter. A prescaler turns the core clock into a microsecond strobe. A second divider turns that strobe into a coarse tick, nominally 100 µs. A 10-bit limit counts those ticks. For example, prescale 12, divide 100 and limit 50 give 5 ms from a 12 MHz clock. Status bits are cleared by writing ones, and a single interrupt line is the OR of the status bits that are enabled.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the fill count, the status vector, the interrupt line, `rd_data` and `rd_perr` are all zero.
- R2: Bytes and their parity flags come out in the order they were accepted. `rd_data`/`rd_perr` hold the popped entry from the cycle after `rd_req`, and `fill_cnt` goes up by one per accepted byte and down by one per pop.
- R3: The queue holds 64 entries. A byte that arrives while 64 are held is discarded, the stored bytes are unchanged, and status bit 2 (overflow) is set.
- R4: A read strobe while the queue is empty leaves `rd_data` and `rd_perr` at their last values and leaves the fill count at zero.
- R5: A one-cycle `flush_req` pulse empties the queue. Any change of `enable`, in either direction, also empties it. While `enable` is low, incoming bytes are ignored.
- R6: Status bit 0 (data ready) is set while the fill count is nonzero.
- R7: Status bit 1 (threshold) is set while the fill count exceeds `thr_level` (0 to 63). A level of 0 sets it on the first byte.
- R8: Status bit 3 (timeout) is set exactly `pre_div` × `tick_div` × `tmo_limit` clock cycles after the last arriving byte, provided the queue stays non-empty throughout. A limit of 0 disables the timeout.
- R9: Every arriving byte, including a discarded one, restarts the timeout interval. The interval does not advance while the queue is empty.
- R10: A 1 in `stat_clr` clears that status bit, and a 0 leaves it alone. A set condition in the same cycle wins over the clear.
- R11: `irq` is high exactly when some status bit is set whose `irq_en` bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Queue enable; any change flushes the queue |
| flush_req | input | 1 | One-cycle flush pulse |
| wr_valid | input | 1 | Received character strobe |
| wr_data | input | 8 | Received character |
| wr_perr | input | 1 | Parity error flag of the received character |
| rd_req | input | 1 | Pop strobe from the reader |
| rd_data | output | 8 | Last popped character |
| rd_perr | output | 1 | Parity flag of the last popped character |
| fill_cnt | output | 7 | Number of held entries (0 to 64) |
| thr_level | input | 6 | Fill threshold |
| pre_div | input | 8 | Prescaler ratio to the microsecond strobe (nonzero) |
| tick_div | input | 8 | Microsecond strobes per tick (nonzero) |
| tmo_limit | input | 10 | Timeout in ticks; 0 disables |
| stat_clr | input | 4 | Write-one-to-clear strobes for the status bits |
| irq_en | input | 4 | Interrupt enable mask |
| status | output | 4 | Sticky status: bit0 ready, bit1 threshold, bit2 overflow, bit3 timeout |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue to exactly 64 and offers one more byte. A design with an off-by-one full test would either take the extra byte or raise overflow one byte early. After the queue is drained it reads once more to catch a design that pops stale entries or lets the count wrap. It times the idle interval to the exact cycle, both with small ratios and with the 12/100/50 setting, so a divider that is off by one reload shows up as a timeout one step early or late. It also checks that a second byte restarts the interval and that an emptied queue never times out. Finally, it clears a status bit in the same cycle that its condition fires, which exposes a design that lets the clear win and loses the event.

// File: rtl/rcq_pkg.sv
// Package: shared constants and types for the receive character queue.
// Assumes 8-bit characters; the status bit order is part of the interface.
package rcq_pkg;
    localparam int CHAR_W   = 8;
    localparam int NUM_STAT = 4;
    localparam int ST_READY = 0;
    localparam int ST_THR   = 1;
    localparam int ST_OVFL  = 2;
    localparam int ST_TMO   = 3;

    typedef struct packed {
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rcq_entry_t;
endpackage

// File: rtl/rcq_store.sv
// Module: circular storage for received entries with a fill counter.
// Assumes DEPTH is a power of two. Flush has priority over push and pop.
// A push while full is dropped and reported on drop_o; a pop while empty
// leaves the output register untouched.
module rcq_store
    import rcq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush_i,
    input  logic       push_i,
    input  rcq_entry_t push_ent_i,
    input  logic       pop_i,
    output rcq_entry_t pop_ent_o,
    output logic [CW-1:0] cnt_o,
    output logic       drop_o
);
    rcq_entry_t      mem [DEPTH];
    logic [AW-1:0]   wptr_q, rptr_q;
    logic [CW-1:0]   cnt_q;
    rcq_entry_t      out_q;
    logic            full, empty, do_push, do_pop;

    // Decode occupancy and qualify the requests.
    always_comb begin
        full    = (cnt_q == CW'(DEPTH));
        empty   = (cnt_q == '0);
        do_push = push_i && !full && !flush_i;
        do_pop  = pop_i && !empty && !flush_i;
        drop_o  = push_i && full && !flush_i;
    end

    // Storage array write port (data only, no reset needed).
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q] <= push_ent_i;
        end
    end

    // Pointer and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + AW'(1);
            if (do_pop)  rptr_q <= rptr_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Read register: captures the head entry on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (do_pop) begin
            out_q <= mem[rptr_q];
        end
    end

    assign pop_ent_o = out_q;
    assign cnt_o     = cnt_q;

    // R2: the count never exceeds the capacity.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R3: a push onto a full queue without a pop keeps it full.
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i && !flush_i) |=> (cnt_q == CW'(DEPTH)));
    // R4: a pop on an empty queue keeps the output register.
    a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_i && !push_i && !flush_i) |=> ($stable(out_q) && cnt_q == '0));
    // R5: flush always leaves the queue empty.
    a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/rcq_timer.sv
// Module: idle-interval timer built from a prescaler, a tick divider and a
// tick counter. It assumes nonzero ratios. It restarts on restart_i, runs only
// while active_i is high, and pulses expire_o once per interval.
// A limit of zero keeps it idle.
module rcq_timer #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 8,
    parameter int TMO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             active_i,
    input  logic [PRE_W-1:0] pre_div_i,
    input  logic [DIV_W-1:0] tick_div_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);
    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic [TMO_W-1:0] tick_q;
    logic             fired_q;
    logic             run, us_stb, tick_stb;

    // Cascade of terminal-count strobes.
    always_comb begin
        run      = active_i && !fired_q && (limit_i != '0);
        us_stb   = run && (pre_q == pre_div_i - PRE_W'(1));
        tick_stb = us_stb && (div_q == tick_div_i - DIV_W'(1));
        expire_o = tick_stb && (tick_q == limit_i - TMO_W'(1));
    end

    // Counter chain: cleared on restart or when idle, advanced while running.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !active_i) begin
            pre_q   <= '0;
            div_q   <= '0;
            tick_q  <= '0;
            fired_q <= 1'b0;
        end else if (run) begin
            pre_q <= us_stb ? '0 : pre_q + PRE_W'(1);
            if (us_stb)   div_q  <= tick_stb ? '0 : div_q + DIV_W'(1);
            if (tick_stb) tick_q <= tick_q + TMO_W'(1);
            if (expire_o) fired_q <= 1'b1;
        end
    end

    // R9: an empty queue keeps the tick count at zero.
    a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i) |=> (tick_q == '0));
    // R8: an expiry fires only once until the next restart.
    a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !restart_i) |=> !expire_o);
endmodule

// File: rtl/rcq_status.sv
// Module: sticky status bits with write-one-to-clear and set priority.
// Assumes set and clear inputs are sampled on the same edge.
module rcq_status #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] set_i,
    input  logic [NS-1:0] clr_i,
    output logic [NS-1:0] stat_o
);
    logic [NS-1:0] st_q;

    for (genvar i = 0; i < NS; i++) begin : g_bit
        // One sticky bit: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)         st_q[i] <= 1'b0;
            else if (set_i[i])  st_q[i] <= 1'b1;
            else if (clr_i[i])  st_q[i] <= 1'b0;
        end

        // R10: a clear without a set empties the bit.
        a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !st_q[i]);
        // R10: a set condition is never lost to a clear.
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> st_q[i]);
    end

    assign stat_o = st_q;
endmodule

// File: rtl/rx_char_queue.sv
// Module: receive character queue top. It joins storage, idle timer and status.
// It assumes the receiver presents one character per wr_valid cycle and that
// the reader pops with single-cycle rd_req strobes.
module rx_char_queue
    import rcq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PRE_W = 8,
    parameter int DIV_W = 8,
    parameter int TMO_W = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flush_req,
    input  logic              wr_valid,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_perr,
    input  logic              rd_req,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_perr,
    output logic [CW-1:0]     fill_cnt,
    input  logic [AW-1:0]     thr_level,
    input  logic [PRE_W-1:0]  pre_div,
    input  logic [DIV_W-1:0]  tick_div,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic [NUM_STAT-1:0] stat_clr,
    input  logic [NUM_STAT-1:0] irq_en,
    output logic [NUM_STAT-1:0] status,
    output logic              irq
);
    logic          en_q;
    logic          flush, push, drop, expire;
    rcq_entry_t    in_ent, out_ent;
    logic [CW-1:0] cnt;
    logic [NUM_STAT-1:0] set_vec;

    // Remember the enable level to detect either transition.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // Request decode and status set conditions.
    always_comb begin
        flush           = flush_req || (enable != en_q);
        push            = wr_valid && enable;
        in_ent.data     = wr_data;
        in_ent.perr     = wr_perr;
        set_vec         = '0;
        set_vec[ST_READY] = (cnt != '0);
        set_vec[ST_THR]   = (cnt > {1'b0, thr_level});
        set_vec[ST_OVFL]  = drop;
        set_vec[ST_TMO]   = expire;
    end

    rcq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .push_i    (push),
        .push_ent_i(in_ent),
        .pop_i     (rd_req),
        .pop_ent_o (out_ent),
        .cnt_o     (cnt),
        .drop_o    (drop)
    );

    rcq_timer #(.PRE_W(PRE_W), .DIV_W(DIV_W), .TMO_W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (push),
        .active_i  (cnt != '0),
        .pre_div_i (pre_div),
        .tick_div_i(tick_div),
        .limit_i   (tmo_limit),
        .expire_o  (expire)
    );

    rcq_status #(.NS(NUM_STAT)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (stat_clr),
        .stat_o (status)
    );

    assign rd_data  = out_ent.data;
    assign rd_perr  = out_ent.perr;
    assign fill_cnt = cnt;
    assign irq      = |(status & irq_en);

    // R5: bytes offered while disabled never change the count.
    a_r5_disabled_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !en_q && !rd_req) |=> $stable(fill_cnt));
    // R3: a drop always leaves the overflow bit set.
    a_r3_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> status[ST_OVFL]);
endmodule

// File: tb/rx_char_queue_tb.sv
// Directed bench for rx_char_queue: one task per scenario.
module rx_char_queue_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, flush_req = 1'b0, wr_valid = 1'b0, wr_perr = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_perr;
    logic [6:0] fill_cnt;
    logic [5:0] thr_level = 6'd63;
    logic [7:0] pre_div = 8'd3, tick_div = 8'd4;
    logic [9:0] tmo_limit = '0;
    logic [3:0] stat_clr = '0, irq_en = '0, status;
    logic       irq;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    rx_char_queue u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .flush_req(flush_req),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_perr(wr_perr), .rd_req(rd_req),
        .rd_data(rd_data), .rd_perr(rd_perr), .fill_cnt(fill_cnt), .thr_level(thr_level),
        .pre_div(pre_div), .tick_div(tick_div), .tmo_limit(tmo_limit),
        .stat_clr(stat_clr), .irq_en(irq_en), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic p);
        wr_valid = 1'b1; wr_data = d; wr_perr = p;
        cyc(1);
        wr_valid = 1'b0;
    endtask

    task automatic pop();
        rd_req = 1'b1;
        cyc(1);
        rd_req = 1'b0;
    endtask

    task automatic clean();
        flush_req = 1'b1; cyc(1); flush_req = 1'b0; cyc(1);
        stat_clr = 4'hF; cyc(1); stat_clr = 4'h0; cyc(1);
    endtask

    task automatic t_reset();
        chk("R1 fill", 32'(fill_cnt), 0);
        chk("R1 status", 32'(status), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rd_data", 32'({rd_perr, rd_data}), 0);
    endtask

    task automatic t_order();
        clean();
        push(8'hA5, 1'b0); push(8'h3C, 1'b1); push(8'h7E, 1'b0);
        chk("R2 fill after 3", 32'(fill_cnt), 3);
        cyc(1);
        chk("R6 ready set", 32'(status[0]), 1);
        pop(); chk("R2 first", 32'({rd_perr, rd_data}), 32'h0A5);
        chk("R2 fill after pop", 32'(fill_cnt), 2);
        pop(); chk("R2 second", 32'({rd_perr, rd_data}), 32'h13C);
        pop(); chk("R2 third", 32'({rd_perr, rd_data}), 32'h07E);
    endtask

    task automatic t_overflow();
        clean();
        for (int i = 0; i < 64; i++) push(8'(i), 1'b0);
        cyc(1);
        chk("R3 fill full", 32'(fill_cnt), 64);
        chk("R3 no early ovfl", 32'(status[2]), 0);
        push(8'hEE, 1'b1);
        chk("R3 fill held", 32'(fill_cnt), 64);
        chk("R3 ovfl set", 32'(status[2]), 1);
        begin
            logic ok = 1'b1;
            for (int i = 0; i < 64; i++) begin
                pop();
                if (rd_data != 8'(i) || rd_perr) ok = 1'b0;
            end
            chk("R3 contents intact", 32'(ok), 1);
        end
        chk("R3 last not dropped byte", 32'(rd_data), 32'h3F);
    endtask

    task automatic t_empty_read();
        pop();
        chk("R4 data kept", 32'(rd_data), 32'h3F);
        chk("R4 fill zero", 32'(fill_cnt), 0);
    endtask

    task automatic t_flush();
        clean();
        push(8'h11, 1'b0); push(8'h22, 1'b0);
        flush_req = 1'b1; cyc(1); flush_req = 1'b0;
        chk("R5 flush pulse", 32'(fill_cnt), 0);
        push(8'h33, 1'b0);
        enable = 1'b0; cyc(1);
        chk("R5 disable flushes", 32'(fill_cnt), 0);
        cyc(1);
        push(8'h44, 1'b0);
        chk("R5 disabled ignores", 32'(fill_cnt), 0);
        enable = 1'b1; cyc(2);
        push(8'h55, 1'b0);
        chk("R5 reenabled accepts", 32'(fill_cnt), 1);
    endtask

    task automatic t_threshold();
        clean();
        thr_level = 6'd0;
        push(8'h01, 1'b0); cyc(1);
        chk("R7 level0 first byte", 32'(status[1]), 1);
        clean();
        thr_level = 6'd3;
        push(8'h01, 1'b0); push(8'h02, 1'b0); push(8'h03, 1'b0); cyc(1);
        chk("R7 at level not set", 32'(status[1]), 0);
        push(8'h04, 1'b0); cyc(1);
        chk("R7 above level set", 32'(status[1]), 1);
        thr_level = 6'd63;
    endtask

    task automatic t_timeout();
        clean();
        pre_div = 8'd3; tick_div = 8'd4; tmo_limit = 10'd5;
        push(8'h10, 1'b0);
        cyc(59); chk("R8 not before 60", 32'(status[3]), 0);
        cyc(1);  chk("R8 at 60", 32'(status[3]), 1);
        clean();
        push(8'h10, 1'b0); cyc(39);
        push(8'h11, 1'b0);
        cyc(59); chk("R9 restart not early", 32'(status[3]), 0);
        cyc(1);  chk("R9 restart fires", 32'(status[3]), 1);
        clean();
        push(8'h12, 1'b0); pop(); cyc(150);
        chk("R9 empty no timeout", 32'(status[3]), 0);
        tmo_limit = 10'd0;
        push(8'h13, 1'b0); cyc(150);
        chk("R8 limit0 disabled", 32'(status[3]), 0);
        clean();
        pre_div = 8'd12; tick_div = 8'd100; tmo_limit = 10'd50;
        push(8'h14, 1'b0);
        cyc(59999); chk("R8 5ms not early", 32'(status[3]), 0);
        cyc(1);     chk("R8 5ms fires", 32'(status[3]), 1);
        tmo_limit = 10'd0;
    endtask

    task automatic t_w1c_irq();
        clean();
        for (int i = 0; i < 65; i++) push(8'(i), 1'b0);
        cyc(1);
        chk("R3 ovfl for w1c", 32'(status[2]), 1);
        stat_clr = 4'b1000; cyc(1); stat_clr = 4'h0; cyc(1);
        chk("R10 zero no effect", 32'(status[2]), 1);
        irq_en = 4'b0100; cyc(1);
        chk("R11 irq enabled bit", 32'(irq), 1);
        irq_en = 4'b1000; cyc(1);
        chk("R11 irq masked", 32'(irq), 0);
        wr_valid = 1'b1; wr_data = 8'hAA; stat_clr = 4'b0100; cyc(1);
        wr_valid = 1'b0; stat_clr = 4'h0; cyc(1);
        chk("R10 set wins", 32'(status[2]), 1);
        stat_clr = 4'b0100; cyc(1); stat_clr = 4'h0; cyc(1);
        chk("R10 clear", 32'(status[2]), 0);
        chk("R10 ready untouched", 32'(status[0]), 1);
        irq_en = 4'b0100; cyc(1);
        chk("R11 irq low after clear", 32'(irq), 0);
        irq_en = 4'h0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        enable = 1'b1; cyc(2);
        t_order();
        t_overflow();
        t_empty_read();
        t_flush();
        t_threshold();
        t_timeout();
        t_w1c_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule